// File: doc/BRIEF.md
# Extended Packet Number Tracker

This block follows the 64-bit packet number of one receive security association while only the low word travels with each frame. Every accepted frame presents its low word. The block rebuilds the full number from a stored high word and an overlap flag, and drives it one cycle later so that replay checking can use it.

The high word belongs to a management agent. When the stream of low words crosses the middle of its range, or wraps from the top of the range back to the bottom, the block raises an object-change event. The event waits on a valid/ready handshake until the agent takes it. The agent answers through a masked modify port that sets the overlap flag, the high word, or both. Frames keep flowing while an update is outstanding. During that time the overlap flag tells the rebuild logic that low words in the lower half already belong to the next high word.

Top module: `epn_tracker`

## Requirements
- R1: After synchronous active-high reset the high word and the overlap flag are zero, no event is pending (`evt_valid` low) and `pn_valid` is low.
- R2: With extended numbering enabled and the overlap flag at 0, the rebuilt number is {high word, low word}.
- R3: With the overlap flag at 1, a low word whose top bit is 0 rebuilds as {high word + 1, low word}, and a low word whose top bit is 1 rebuilds as {high word, low word}.
- R4: With `cfg_epn_en` low, the rebuilt number is {zero, low word}, no wrap event is raised and the crossing-tracking state stays where it was.
- R5: When an accepted low word has top bit 1 and the previous crossing state is "lower half", exactly one half-wrap event is raised, with `evt_kind` = 0.
- R6: When an accepted low word has top bit 0 and the crossing state is "upper half", exactly one full-wrap event is raised, with `evt_kind` = 1.
- R7: A raised event holds `evt_valid`, its kind and its payload until a cycle in which `evt_ready` is high. The payload carries code 0x27 on `evt_code`, the object type and the object identifier.
- R8: When both kinds are pending, the half-wrap event is offered first and the full-wrap event follows after it is accepted.
- R9: A modify with `mod_sel` bit 0 set loads the overlap flag, and a modify with bit 1 set loads the high word. A field whose select bit is clear keeps its value.
- R10: `pn_valid` pulses in the cycle after each `pkt_valid`, and frames are accepted while an event is pending.
- R11: A frame presented in the same cycle as a modify is rebuilt with the values from before the modify.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_epn_en | input | 1 | Extended numbering enable |
| pkt_valid | input | 1 | Accepted frame strobe |
| pkt_lo | input | LO_W | Low word of the frame's packet number |
| pn_valid | output | 1 | Rebuilt number is valid |
| pn_full | output | HI_W+LO_W | Rebuilt packet number |
| mod_valid | input | 1 | Modify strobe from management |
| mod_sel | input | 2 | Field select: bit 0 overlap, bit 1 high word |
| mod_overlap | input | 1 | New overlap flag (1 = old, 0 = new) |
| mod_hi | input | HI_W | New high word |
| evt_valid | output | 1 | Wrap event offered |
| evt_ready | input | 1 | Management accepts the event |
| evt_kind | output | 1 | 0 = half-wrap, 1 = full-wrap |
| evt_code | output | 8 | Event type code, 0x27 |
| evt_obj_type | output | TYPE_W | Object type of the event payload |
| evt_obj_id | output | ID_W | Object identifier of the event payload |

## Verification
The checker assumes that accepted low words rise monotonically between wraps, so that a change in the top bit always marks a real crossing and never a late or reordered frame. It also assumes that management never lets a second crossing of the same kind happen while the first is still pending. The directed stimulus walks the low word up through each quarter of its range in order. It accepts or deliberately stalls each event long before another crossing could occur, and it exercises every modify mask value and the case where a frame and a modify share a cycle.

// File: rtl/epn_trk_pkg.sv
package epn_trk_pkg;

   typedef enum logic {
      WRAP_HALF = 1'b0,
      WRAP_FULL = 1'b1
   } wrap_kind_e;

   localparam logic [7:0] OBJ_CHANGE_CODE = 8'h27;
   localparam int         NUM_WRAP_KINDS  = 2;

   localparam int SEL_OVERLAP = 0;
   localparam int SEL_HIGH    = 1;

endpackage

// File: rtl/epn_ctl_regs.sv
module epn_ctl_regs #(
   parameter int HI_W = 32
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            mod_valid,
   input  logic [1:0]      mod_sel,
   input  logic            mod_overlap,
   input  logic [HI_W-1:0] mod_hi,
   output logic [HI_W-1:0] hi_q,
   output logic            ovl_q
);
   import epn_trk_pkg::*;

   logic wr_ovl;
   logic wr_hi;

   assign wr_ovl = mod_valid && mod_sel[SEL_OVERLAP];
   assign wr_hi  = mod_valid && mod_sel[SEL_HIGH];

   always_ff @(posedge clk) begin
      if (rst) begin
         ovl_q <= 1'b0;
      end else if (wr_ovl) begin
         ovl_q <= mod_overlap;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         hi_q <= '0;
      end else if (wr_hi) begin
         hi_q <= mod_hi;
      end
   end

endmodule

// File: rtl/epn_wrap_detect.sv
module epn_wrap_detect #(
   parameter int LO_W = 32
) (
   input  logic clk,
   input  logic rst,
   input  logic en,
   input  logic pkt_valid,
   input  logic pkt_msb,
   input  logic evt_ready,
   output logic evt_valid,
   output logic evt_kind
);
   import epn_trk_pkg::*;

   logic                      upper_phase_q;
   logic [NUM_WRAP_KINDS-1:0] set_vec;
   logic [NUM_WRAP_KINDS-1:0] take_vec;
   logic [NUM_WRAP_KINDS-1:0] pend_q;
   logic                      step;

   assign step = en && pkt_valid;

   // Crossing raised on a change of the low word's top bit.
   assign set_vec[WRAP_HALF] = step && !upper_phase_q &&  pkt_msb;
   assign set_vec[WRAP_FULL] = step &&  upper_phase_q && !pkt_msb;

   always_ff @(posedge clk) begin
      if (rst) begin
         upper_phase_q <= 1'b0;
      end else if (step) begin
         upper_phase_q <= pkt_msb;
      end
   end

   // Half-wrap has precedence when both are waiting.
   always_comb begin
      evt_valid = |pend_q;
      evt_kind  = pend_q[WRAP_HALF] ? WRAP_HALF : WRAP_FULL;
   end

   genvar k;
   generate
      for (k = 0; k < NUM_WRAP_KINDS; k++) begin : g_pend
         assign take_vec[k] = evt_valid && evt_ready && (evt_kind == k[0]);

         always_ff @(posedge clk) begin
            if (rst) begin
               pend_q[k] <= 1'b0;
            end else if (set_vec[k]) begin
               pend_q[k] <= 1'b1;
            end else if (take_vec[k]) begin
               pend_q[k] <= 1'b0;
            end
         end
      end
   endgenerate

   generate
      if (LO_W < 2) begin : g_bad_lo
         $error("epn_wrap_detect: LO_W must be at least 2");
      end
   endgenerate

endmodule

// File: rtl/epn_rebuild.sv
module epn_rebuild #(
   parameter int LO_W    = 32,
   parameter int HI_W    = 32,
   parameter bit OUT_REG = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 en,
   input  logic                 pkt_valid,
   input  logic [LO_W-1:0]      pkt_lo,
   input  logic [HI_W-1:0]      hi,
   input  logic                 ovl,
   output logic                 pn_valid,
   output logic [HI_W+LO_W-1:0] pn_full
);
   localparam int PN_W = HI_W + LO_W;

   logic [HI_W-1:0] hi_pick;
   logic [PN_W-1:0] pn_comb;

   always_comb begin
      if (!en) begin
         hi_pick = '0;
      end else if (ovl && !pkt_lo[LO_W-1]) begin
         hi_pick = hi + {{(HI_W-1){1'b0}}, 1'b1};
      end else begin
         hi_pick = hi;
      end
      pn_comb = {hi_pick, pkt_lo};
   end

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk) begin
            if (rst) begin
               pn_valid <= 1'b0;
               pn_full  <= '0;
            end else begin
               pn_valid <= pkt_valid;
               if (pkt_valid) begin
                  pn_full <= pn_comb;
               end
            end
         end
      end else begin : g_comb
         assign pn_valid = pkt_valid;
         assign pn_full  = pn_comb;
      end
   endgenerate

endmodule

// File: rtl/epn_tracker.sv
module epn_tracker #(
   parameter int                LO_W     = 32,
   parameter int                HI_W     = 32,
   parameter int                TYPE_W   = 16,
   parameter int                ID_W     = 32,
   parameter logic [TYPE_W-1:0] OBJ_TYPE = 16'h0027,
   parameter logic [ID_W-1:0]   OBJ_ID   = 32'h0000_0001,
   parameter bit                OUT_REG  = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 cfg_epn_en,
   input  logic                 pkt_valid,
   input  logic [LO_W-1:0]      pkt_lo,
   output logic                 pn_valid,
   output logic [HI_W+LO_W-1:0] pn_full,
   input  logic                 mod_valid,
   input  logic [1:0]           mod_sel,
   input  logic                 mod_overlap,
   input  logic [HI_W-1:0]      mod_hi,
   output logic                 evt_valid,
   input  logic                 evt_ready,
   output logic                 evt_kind,
   output logic [7:0]           evt_code,
   output logic [TYPE_W-1:0]    evt_obj_type,
   output logic [ID_W-1:0]      evt_obj_id
);
   import epn_trk_pkg::*;

   logic [HI_W-1:0] hi_q;
   logic            ovl_q;

   generate
      if (HI_W < 1) begin : g_bad_hi
         $error("epn_tracker: HI_W must be positive");
      end
      if (TYPE_W < 1 || ID_W < 1) begin : g_bad_payload
         $error("epn_tracker: payload widths must be positive");
      end
   endgenerate

   epn_ctl_regs #(.HI_W(HI_W)) u_regs (
      .clk         (clk),
      .rst         (rst),
      .mod_valid   (mod_valid),
      .mod_sel     (mod_sel),
      .mod_overlap (mod_overlap),
      .mod_hi      (mod_hi),
      .hi_q        (hi_q),
      .ovl_q       (ovl_q)
   );

   epn_wrap_detect #(.LO_W(LO_W)) u_wrap (
      .clk       (clk),
      .rst       (rst),
      .en        (cfg_epn_en),
      .pkt_valid (pkt_valid),
      .pkt_msb   (pkt_lo[LO_W-1]),
      .evt_ready (evt_ready),
      .evt_valid (evt_valid),
      .evt_kind  (evt_kind)
   );

   epn_rebuild #(.LO_W(LO_W), .HI_W(HI_W), .OUT_REG(OUT_REG)) u_rebuild (
      .clk       (clk),
      .rst       (rst),
      .en        (cfg_epn_en),
      .pkt_valid (pkt_valid),
      .pkt_lo    (pkt_lo),
      .hi        (hi_q),
      .ovl       (ovl_q),
      .pn_valid  (pn_valid),
      .pn_full   (pn_full)
   );

   assign evt_code     = OBJ_CHANGE_CODE;
   assign evt_obj_type = OBJ_TYPE;
   assign evt_obj_id   = OBJ_ID;

endmodule

// File: rtl/epn_tracker_chk.sv
module epn_tracker_chk #(
   parameter int LO_W    = 32,
   parameter int HI_W    = 32,
   parameter bit OUT_REG = 1'b1
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 cfg_epn_en,
   input logic                 pkt_valid,
   input logic [LO_W-1:0]      pkt_lo,
   input logic                 pn_valid,
   input logic [HI_W+LO_W-1:0] pn_full,
   input logic                 evt_valid,
   input logic                 evt_ready,
   input logic                 evt_kind
);

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      rst |=> (!evt_valid && !pn_valid));

   // R7
   evt_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (evt_valid && !evt_ready) |=> (evt_valid && $stable(evt_kind)));

   // R4
   no_evt_when_off_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(evt_valid) |-> $past(cfg_epn_en && pkt_valid));

   // R8
   half_first_chk: assert property (@(posedge clk) disable iff (rst)
      (evt_valid && !evt_ready && evt_kind == 1'b0) |=> (evt_kind == 1'b0));

   generate
      if (OUT_REG) begin : g_lat
         // R10
         pn_latency_chk: assert property (@(posedge clk) disable iff (rst)
            pkt_valid |=> pn_valid);

         // R10
         pn_quiet_chk: assert property (@(posedge clk) disable iff (rst)
            !pkt_valid |=> !pn_valid);

         // R2
         pn_low_chk: assert property (@(posedge clk) disable iff (rst)
            pkt_valid |=> (pn_full[LO_W-1:0] == $past(pkt_lo)));

         // R4
         pn_plain_chk: assert property (@(posedge clk) disable iff (rst)
            (pkt_valid && !cfg_epn_en) |=> (pn_full[HI_W+LO_W-1:LO_W] == '0));
      end
   endgenerate

endmodule

bind epn_tracker epn_tracker_chk #(
   .LO_W    (LO_W),
   .HI_W    (HI_W),
   .OUT_REG (OUT_REG)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .cfg_epn_en (cfg_epn_en),
   .pkt_valid  (pkt_valid),
   .pkt_lo     (pkt_lo),
   .pn_valid   (pn_valid),
   .pn_full    (pn_full),
   .evt_valid  (evt_valid),
   .evt_ready  (evt_ready),
   .evt_kind   (evt_kind)
);

// File: tb/epn_tracker_bench.sv
module epn_tracker_bench;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic        clk = 1'b0;
   logic        rst;
   logic        cfg_epn_en;
   logic        pkt_valid;
   logic [31:0] pkt_lo;
   logic        pn_valid;
   logic [63:0] pn_full;
   logic        mod_valid;
   logic [1:0]  mod_sel;
   logic        mod_overlap;
   logic [31:0] mod_hi;
   logic        evt_valid;
   logic        evt_ready;
   logic        evt_kind;
   logic [7:0]  evt_code;
   logic [15:0] evt_obj_type;
   logic [31:0] evt_obj_id;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   epn_tracker u_epn_tracker (
      .clk          (clk),
      .rst          (rst),
      .cfg_epn_en   (cfg_epn_en),
      .pkt_valid    (pkt_valid),
      .pkt_lo       (pkt_lo),
      .pn_valid     (pn_valid),
      .pn_full      (pn_full),
      .mod_valid    (mod_valid),
      .mod_sel      (mod_sel),
      .mod_overlap  (mod_overlap),
      .mod_hi       (mod_hi),
      .evt_valid    (evt_valid),
      .evt_ready    (evt_ready),
      .evt_kind     (evt_kind),
      .evt_code     (evt_code),
      .evt_obj_type (evt_obj_type),
      .evt_obj_id   (evt_obj_id)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // Frame: drive at a falling edge, result visible one falling edge later.
   task automatic send_pkt(input logic [31:0] lo, input logic [63:0] exp_pn,
                           input string req);
      @(negedge clk);
      pkt_valid = 1'b1;
      pkt_lo    = lo;
      @(negedge clk);
      pkt_valid = 1'b0;
      chk(pn_valid == 1'b1, {req, " pn_valid"}, 64'(pn_valid), 64'd1);
      chk(pn_full == exp_pn, {req, " pn_full"}, pn_full, exp_pn);
   endtask

   task automatic modify(input logic [1:0] sel, input logic ovl, input logic [31:0] hi);
      @(negedge clk);
      mod_valid   = 1'b1;
      mod_sel     = sel;
      mod_overlap = ovl;
      mod_hi      = hi;
      @(negedge clk);
      mod_valid = 1'b0;
   endtask

   task automatic take_evt(input logic exp_kind, input string req);
      chk(evt_valid == 1'b1, {req, " evt_valid"}, 64'(evt_valid), 64'd1);
      chk(evt_kind == exp_kind, {req, " evt_kind"}, 64'(evt_kind), 64'(exp_kind));
      evt_ready = 1'b1;
      @(negedge clk);
      evt_ready = 1'b0;
   endtask

   task automatic t_reset();
      chk(evt_valid == 1'b0, "R1 evt_valid", 64'(evt_valid), 64'd0);
      chk(pn_valid == 1'b0, "R1 pn_valid", 64'(pn_valid), 64'd0);
      send_pkt(32'h0000_0005, 64'h0000_0000_0000_0005, "R1 R2 zero high");
   endtask

   task automatic t_half_wrap();
      send_pkt(32'h7FFF_FFF0, 64'h0000_0000_7FFF_FFF0, "R2 below half");
      chk(evt_valid == 1'b0, "R5 no early event", 64'(evt_valid), 64'd0);
      send_pkt(32'h8000_0001, 64'h0000_0000_8000_0001, "R5 crossing frame");
      chk(evt_valid == 1'b1, "R5 half raised", 64'(evt_valid), 64'd1);
      chk(evt_kind == 1'b0, "R5 half kind", 64'(evt_kind), 64'd0);
      chk(evt_code == 8'h27, "R7 code", 64'(evt_code), 64'h27);
      chk(evt_obj_type == 16'h0027, "R7 type", 64'(evt_obj_type), 64'h27);
      chk(evt_obj_id == 32'h1, "R7 id", 64'(evt_obj_id), 64'h1);
      repeat (3) @(negedge clk);
      chk(evt_valid == 1'b1, "R7 held while stalled", 64'(evt_valid), 64'd1);
      send_pkt(32'h8000_0002, 64'h0000_0000_8000_0002, "R10 frame while pending");
      take_evt(1'b0, "R5 R7 accept");
      chk(evt_valid == 1'b0, "R5 single event", 64'(evt_valid), 64'd0);
   endtask

   task automatic t_full_wrap();
      modify(2'b01, 1'b1, 32'hDEAD_BEEF);
      send_pkt(32'h9000_0000, 64'h0000_0000_9000_0000, "R9 R3 high kept, upper half");
      send_pkt(32'h0000_0010, 64'h0000_0001_0000_0010, "R3 R6 lower half uses high+1");
      chk(evt_valid == 1'b1, "R6 full raised", 64'(evt_valid), 64'd1);
      chk(evt_kind == 1'b1, "R6 full kind", 64'(evt_kind), 64'd1);
      modify(2'b10, 1'b0, 32'h0000_0001);
      send_pkt(32'h0000_0020, 64'h0000_0002_0000_0020, "R9 overlap kept");
      modify(2'b11, 1'b0, 32'h0000_0001);
      send_pkt(32'h0000_0030, 64'h0000_0001_0000_0030, "R9 R2 both fields");
      take_evt(1'b1, "R6 accept");
      chk(evt_valid == 1'b0, "R6 single event", 64'(evt_valid), 64'd0);
   endtask

   task automatic t_order();
      send_pkt(32'h8000_0000, 64'h0000_0001_8000_0000, "R8 half frame");
      send_pkt(32'h0000_0001, 64'h0000_0001_0000_0001, "R8 full frame");
      take_evt(1'b0, "R8 half first");
      take_evt(1'b1, "R8 full second");
      chk(evt_valid == 1'b0, "R8 drained", 64'(evt_valid), 64'd0);
   endtask

   task automatic t_same_cycle();
      @(negedge clk);
      mod_valid   = 1'b1;
      mod_sel     = 2'b11;
      mod_overlap = 1'b1;
      mod_hi      = 32'h0000_0005;
      pkt_valid   = 1'b1;
      pkt_lo      = 32'h0000_0040;
      @(negedge clk);
      mod_valid = 1'b0;
      pkt_valid = 1'b0;
      chk(pn_full == 64'h0000_0001_0000_0040, "R11 old values",
          pn_full, 64'h0000_0001_0000_0040);
      send_pkt(32'h0000_0050, 64'h0000_0006_0000_0050, "R11 new values");
      send_pkt(32'h8000_0050, 64'h0000_0005_8000_0050, "R3 upper half");
      take_evt(1'b0, "R5 second half wrap");
   endtask

   task automatic t_disabled();
      cfg_epn_en = 1'b0;
      send_pkt(32'h0000_0010, 64'h0000_0000_0000_0010, "R4 plain number");
      send_pkt(32'h9000_0000, 64'h0000_0000_9000_0000, "R4 plain upper");
      send_pkt(32'h0000_0001, 64'h0000_0000_0000_0001, "R4 plain wrap");
      chk(evt_valid == 1'b0, "R4 no event", 64'(evt_valid), 64'd0);
      cfg_epn_en = 1'b1;
      send_pkt(32'h9000_0001, 64'h0000_0005_9000_0001, "R4 phase kept");
      chk(evt_valid == 1'b0, "R4 no event after enable", 64'(evt_valid), 64'd0);
   endtask

   initial begin
      rst = 1'b1;
      cfg_epn_en = 1'b1;
      pkt_valid = 1'b0;
      pkt_lo = '0;
      mod_valid = 1'b0;
      mod_sel = '0;
      mod_overlap = 1'b0;
      mod_hi = '0;
      evt_ready = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_half_wrap();
      t_full_wrap();
      t_order();
      t_same_cycle();
      t_disabled();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule